// File: doc/BRIEF.md
# Switch-Selectable I/O Port Decoder

This block turns one I/O cycle on an ISA-style expansion bus into a single board select and eight device selects. A three-position switch setting places the board's 64-port block at one of eight bases in the upper half of the port space, from 0x200 up to 0x3C0. A cycle selects the board when the address falls in that block, no DMA cycle is running, and at least one of the read or write strobes is active. The qualified match then enables a one-of-eight split on the middle address bits. Each device select covers eight consecutive ports.

The eight windows have fixed roles, in order of the middle address field. Window 0 is the eight-channel analog input converter, window 1 the first analog output converter, window 2 the second (optional) output converter, window 3 the converter ready flag plus three digital inputs, and window 4 the programmable parallel interface. Windows 5, 6 and 7 are spare selects. The three lowest address bits go straight through to the devices. Qualified read and write strobes and a buffered bus reset are also provided. The whole path is combinational, so the selects follow the bus inputs with no clock delay.

Top module: `io_port_decoder`

## Requirements
- R1: The board select (`board_sel_n`, active low) never asserts unless address bit 9 is 1, so only ports 0x200 to 0x3FF can respond.
- R2: Bit i of `base_sw` (1 = switch closed/ON, 0 = open/OFF) must match address bit 6+i: an ON switch requires that bit to be 0 and an OFF switch requires it to be 1. `base_sw = 3'b111` gives base 0x200 and `3'b000` gives base 0x3C0.
- R3: While `aen` is 1 (a DMA cycle), no select of any kind asserts.
- R4: While both `ior_n` and `iow_n` are 1, no select of any kind asserts.
- R5: `board_sel_n` is 0 exactly when R1, R2, R3 and R4 all hold at the same time.
- R6: `dev_sel_n[k]` is 0 exactly when `board_sel_n` is 0 and address bits 5:3 equal k. Roles: 0 analog input converter, 1 output converter 1, 2 output converter 2, 3 ready flag and digital inputs, 4 parallel interface, 5 to 7 spare.
- R7: At most one bit of `dev_sel_n` is 0 at any time. All bits are 1 whenever `board_sel_n` is 1.
- R8: `rd_sel_n` is 0 exactly when `board_sel_n` is 0 and `ior_n` is 0. `wr_sel_n` is 0 exactly when `board_sel_n` is 0 and `iow_n` is 0.
- R9: `dev_addr` always equals address bits 2:0, and those bits have no effect on any select.
- R10: `bus_rst_out` always equals `bus_rst_in`, and the reset level has no effect on any select.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| io_addr | input | 10 | Port address from the bus |
| aen | input | 1 | Address enable, high during DMA cycles |
| ior_n | input | 1 | I/O read strobe, active low |
| iow_n | input | 1 | I/O write strobe, active low |
| base_sw | input | 3 | Base switch setting, 1 = closed/ON |
| bus_rst_in | input | 1 | Bus reset |
| board_sel_n | output | 1 | Qualified board select, active low |
| dev_sel_n | output | 8 | Device window selects, active low |
| rd_sel_n | output | 1 | Qualified read strobe, active low |
| wr_sel_n | output | 1 | Qualified write strobe, active low |
| dev_addr | output | 3 | Address bits 2:0 passed to the devices |
| bus_rst_out | output | 1 | Buffered bus reset |

## Verification
The two functions that can act together are the base match and the window split, combined with strobe qualification: an address can match the base and window while a DMA cycle or an idle strobe pair should suppress every select. The bench provokes this by sweeping every address under every switch setting with `aen` at both levels and all four strobe combinations. At each point it judges the board select, the eight device selects and both qualified strobes against values it works out from the address fields. It also counts, for each setting and window, how many addresses respond, and expects exactly eight.

// File: rtl/io_dec_pkg.sv
package io_dec_pkg;
  localparam int unsigned ADDR_W    = 10;
  localparam int unsigned SW_W      = 3;
  localparam int unsigned WIN_BITS  = 3;
  localparam int unsigned WIN_LSB   = 3;
  localparam int unsigned WIN_CNT   = 1 << WIN_BITS;
  localparam int unsigned BASE_LSB  = WIN_LSB + WIN_BITS;

  typedef enum logic [WIN_BITS-1:0] {
    WIN_ADC_IN   = 3'd0,
    WIN_DAC_A    = 3'd1,
    WIN_DAC_B    = 3'd2,
    WIN_RDY_DIN  = 3'd3,
    WIN_PIO      = 3'd4,
    WIN_SPARE_0  = 3'd5,
    WIN_SPARE_1  = 3'd6,
    WIN_SPARE_2  = 3'd7
  } win_role_e;
endpackage

// File: rtl/io_base_match.sv
module io_base_match #(
  parameter int unsigned ADDR_W   = 10,
  parameter int unsigned SW_W     = 3,
  parameter int unsigned BASE_LSB = 6
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic [SW_W-1:0]   sw_on,
  input  logic              aen,
  input  logic              ior_n,
  input  logic              iow_n,
  output logic              hit
);
  localparam int unsigned TOP_BIT = ADDR_W - 1;

  logic [SW_W-1:0] bit_eq;
  logic            strobe_any;

  // A closed switch ties its comparator input low, an open one pulls it high.
  genvar gi;
  generate
    for (gi = 0; gi < SW_W; gi++) begin : g_cmp
      assign bit_eq[gi] = (addr[BASE_LSB+gi] == ~sw_on[gi]);
    end
  endgenerate

  assign strobe_any = ~(ior_n & iow_n);

  always_comb begin
    hit = (&bit_eq) & addr[TOP_BIT] & ~aen & strobe_any;
  end
endmodule

// File: rtl/io_win_split.sv
module io_win_split #(
  parameter int unsigned WIN_BITS = 3,
  parameter int unsigned WIN_CNT  = 8
) (
  input  logic                en,
  input  logic [WIN_BITS-1:0] win,
  output logic [WIN_CNT-1:0]  sel_n
);
  genvar gw;
  generate
    for (gw = 0; gw < WIN_CNT; gw++) begin : g_win
      assign sel_n[gw] = ~(en & (win == WIN_BITS'(gw)));
    end
  endgenerate
endmodule

// File: rtl/io_strobe_qual.sv
module io_strobe_qual (
  input  logic hit,
  input  logic ior_n,
  input  logic iow_n,
  output logic rd_n,
  output logic wr_n
);
  always_comb begin
    rd_n = ~(hit & ~ior_n);
    wr_n = ~(hit & ~iow_n);
  end
endmodule

// File: rtl/io_port_decoder.sv
module io_port_decoder
  import io_dec_pkg::*;
(
  input  logic [ADDR_W-1:0]   io_addr,
  input  logic                aen,
  input  logic                ior_n,
  input  logic                iow_n,
  input  logic [SW_W-1:0]     base_sw,
  input  logic                bus_rst_in,
  output logic                board_sel_n,
  output logic [WIN_CNT-1:0]  dev_sel_n,
  output logic                rd_sel_n,
  output logic                wr_sel_n,
  output logic [WIN_LSB-1:0]  dev_addr,
  output logic                bus_rst_out
);
  logic                hit;
  logic [WIN_BITS-1:0] win;

  io_base_match #(
    .ADDR_W  (ADDR_W),
    .SW_W    (SW_W),
    .BASE_LSB(BASE_LSB)
  ) u_match (
    .addr (io_addr),
    .sw_on(base_sw),
    .aen  (aen),
    .ior_n(ior_n),
    .iow_n(iow_n),
    .hit  (hit)
  );

  assign win = io_addr[WIN_LSB +: WIN_BITS];

  io_win_split #(
    .WIN_BITS(WIN_BITS),
    .WIN_CNT (WIN_CNT)
  ) u_split (
    .en   (hit),
    .win  (win),
    .sel_n(dev_sel_n)
  );

  io_strobe_qual u_qual (
    .hit  (hit),
    .ior_n(ior_n),
    .iow_n(iow_n),
    .rd_n (rd_sel_n),
    .wr_n (wr_sel_n)
  );

  assign board_sel_n = ~hit;
  assign dev_addr    = io_addr[WIN_LSB-1:0];
  assign bus_rst_out = bus_rst_in;
endmodule

// File: rtl/io_port_decoder_chk.sv
module io_port_decoder_chk
  import io_dec_pkg::*;
(
  input logic [ADDR_W-1:0]  io_addr,
  input logic               aen,
  input logic               ior_n,
  input logic               iow_n,
  input logic [SW_W-1:0]    base_sw,
  input logic               bus_rst_in,
  input logic               board_sel_n,
  input logic [WIN_CNT-1:0] dev_sel_n,
  input logic               rd_sel_n,
  input logic               wr_sel_n,
  input logic [WIN_LSB-1:0] dev_addr,
  input logic               bus_rst_out
);
  always_comb begin
    AST_SEL_NEEDS_A9: assert (board_sel_n || io_addr[ADDR_W-1]) else $error("select below 0x200"); // R1
    AST_SEL_NEEDS_BASE: assert (board_sel_n || (io_addr[BASE_LSB +: SW_W] == ~base_sw)) else $error("base mismatch"); // R2
    AST_SEL_NEEDS_NO_DMA: assert (board_sel_n || !aen) else $error("select during DMA"); // R3
    AST_SEL_NEEDS_STROBE: assert (board_sel_n || !(ior_n && iow_n)) else $error("select with idle strobes"); // R4
    AST_DEV_WINDOW: assert (board_sel_n || !dev_sel_n[io_addr[WIN_LSB +: WIN_BITS]]) else $error("wrong window"); // R6
    AST_DEV_ONEHOT: assert ($onehot0(~dev_sel_n)) else $error("two device selects"); // R7
    AST_DEV_IDLE: assert (!board_sel_n || (&dev_sel_n)) else $error("device select without board"); // R7
    AST_RD_QUAL: assert (rd_sel_n || (!board_sel_n && !ior_n)) else $error("bad read strobe"); // R8
    AST_WR_QUAL: assert (wr_sel_n || (!board_sel_n && !iow_n)) else $error("bad write strobe"); // R8
    AST_LOW_ADDR: assert (dev_addr == io_addr[WIN_LSB-1:0]) else $error("low address"); // R9
    AST_RST_PASS: assert (bus_rst_out == bus_rst_in) else $error("reset pass"); // R10
  end
endmodule

bind io_port_decoder io_port_decoder_chk u_chk (.*);

// File: tb/tb_io_port_decoder.sv
module tb_io_port_decoder;
  logic       clk;
  logic [9:0] io_addr;
  logic       aen, ior_n, iow_n, bus_rst_in;
  logic [2:0] base_sw;
  logic       board_sel_n, rd_sel_n, wr_sel_n, bus_rst_out;
  logic [7:0] dev_sel_n;
  logic [2:0] dev_addr;

  int total = 0;
  int bad   = 0;
  bit done  = 0;
  int hits [8][8];

  io_port_decoder dut (
    .io_addr(io_addr), .aen(aen), .ior_n(ior_n), .iow_n(iow_n),
    .base_sw(base_sw), .bus_rst_in(bus_rst_in),
    .board_sel_n(board_sel_n), .dev_sel_n(dev_sel_n),
    .rd_sel_n(rd_sel_n), .wr_sel_n(wr_sel_n),
    .dev_addr(dev_addr), .bus_rst_out(bus_rst_out)
  );

  initial clk = 0;
  always #4 clk = ~clk;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h addr=%0h sw=%0d aen=%0b rd=%0b wr=%0b",
               req, act, exp, io_addr, base_sw, aen, ior_n, iow_n);
    end
  endtask

  initial begin
    #1500000;
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog actual=0 expected=1");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    io_addr = '0; aen = 1'b0; ior_n = 1'b1; iow_n = 1'b1; base_sw = '0; bus_rst_in = 1'b1;
    foreach (hits[i, j]) hits[i][j] = 0;
    @(negedge clk);
    // Idle state: strobes high, reset asserted
    chk(board_sel_n === 1'b1, "R4 idle board", int'(board_sel_n), 1);
    chk(dev_sel_n === 8'hFF, "R7 idle devs", int'(dev_sel_n), 8'hFF);
    chk(bus_rst_out === 1'b1, "R10 reset pass", int'(bus_rst_out), 1);

    for (int sw = 0; sw < 8; sw++) begin
      for (int a = 0; a < 1024; a++) begin
        for (int dm = 0; dm < 2; dm++) begin
          for (int st = 0; st < 4; st++) begin
            bit exp_hit;
            bit [7:0] exp_dev;
            bit [2:0] exp_base;
            base_sw    = 3'(sw);
            io_addr    = 10'(a);
            aen        = dm[0];
            ior_n      = st[0];
            iow_n      = st[1];
            bus_rst_in = a[0] ^ a[4] ^ st[0];
            #1;
            exp_base = 3'(~sw);
            exp_hit  = (a >= 'h200) && (((a >> 6) & 7) == exp_base) && (dm == 0) && (st != 3);
            exp_dev  = 8'hFF;
            if (exp_hit) exp_dev[(a >> 3) & 7] = 1'b0;
            chk(board_sel_n === !exp_hit, "R5 board", int'(board_sel_n), int'(!exp_hit));
            chk(dev_sel_n === exp_dev, "R6 window", int'(dev_sel_n), int'(exp_dev));
            chk(rd_sel_n === !(exp_hit && !st[0]), "R8 read", int'(rd_sel_n), int'(!(exp_hit && !st[0])));
            chk(wr_sel_n === !(exp_hit && !st[1]), "R8 write", int'(wr_sel_n), int'(!(exp_hit && !st[1])));
            chk(dev_addr === 3'(a), "R9 low addr", int'(dev_addr), a & 7);
            chk(bus_rst_out === bus_rst_in, "R10 reset", int'(bus_rst_out), int'(bus_rst_in));
            if (dm == 0 && st == 2) begin
              for (int k = 0; k < 8; k++) if (dev_sel_n[k] === 1'b0) hits[sw][k]++;
            end
            @(negedge clk);
          end
        end
      end
    end

    // Each setting: every window answers at exactly 8 ports (R6, R2)
    for (int sw = 0; sw < 8; sw++)
      for (int k = 0; k < 8; k++)
        chk(hits[sw][k] == 8, "R6 window size", hits[sw][k], 8);

    // Named corners: R1 below 0x200 never answers; R2 base ends; R3 DMA blocks
    base_sw = 3'b111; io_addr = 10'h000; aen = 0; ior_n = 0; iow_n = 1; #1;
    chk(board_sel_n === 1'b1, "R1 alias 0x000", int'(board_sel_n), 1);
    io_addr = 10'h200; #1;
    chk(dev_sel_n === 8'hFE, "R2 base 0x200 adc", int'(dev_sel_n), 8'hFE);
    base_sw = 3'b000; io_addr = 10'h3E0; #1;
    chk(dev_sel_n === 8'hEF, "R2 base 0x3C0 pio", int'(dev_sel_n), 8'hEF);
    aen = 1; #1;
    chk(board_sel_n === 1'b1, "R3 dma block", int'(board_sel_n), 1);
    aen = 0; ior_n = 1; iow_n = 1; #1;
    chk(rd_sel_n === 1'b1 && wr_sel_n === 1'b1, "R4 no strobe", int'({rd_sel_n, wr_sel_n}), 3);
    @(negedge clk);

    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule